// File: doc/BRIEF.md
# Phase-Qualified Display Soft Switches

This block keeps two memory-mapped display switches for a 6502-style bus: a page-select flag and a graphics-mode flag. Any CPU access to one of four addresses near $C054 sets or clears one of them. The data bus and the read/write line play no part, so reads and writes have the same effect. The block works in a fast clock domain and oversamples the asynchronous phase-0 clock and the address bus through synchronizer stages.

A switch may change only while the bus phase is high. Once the phase ends, the address lines decay and can pass through spurious values for tens of nanoseconds. If those values were decoded directly, a switch could be thrown by mistake. To prevent this, the block captures the address into a register once per high phase, after a short settle count, and decodes only that captured value. The captured decode is applied once and only while the phase is still high.

A four-state controller sequences each phase: `ST_LOW` waits for the phase, `ST_SETTLE` counts settle cycles and captures the address, `ST_APPLY` commits the decode and `ST_HOLD` waits for the phase to end. The transitions are:
- `ST_LOW` to `ST_SETTLE` when the synchronized phase is high.
- `ST_SETTLE` to `ST_APPLY` after capture.
- `ST_SETTLE` to `ST_LOW` if the phase drops before capture.
- `ST_APPLY` to `ST_HOLD` always.
- `ST_HOLD` to `ST_LOW` when the phase is low.

Top module: `disp_switch_top`

## Requirements
- R1: Synchronous active-high `rst` clears both flags, and they read 0 in the cycle after reset.
- R2: A qualified access to $C054 clears `page_sel`, and one to $C055 sets it. Address bit 0 chooses set (1) or clear (0).
- R3: A qualified access to $C056 clears `gfx_mode`, and one to $C057 sets it.
- R4: A qualified access to any other address, such as $C058 or $0700, changes neither flag.
- R5: An address held while `phi0` is low never changes a flag.
- R6: A switch address that appears just after `phi0` falls (the decaying-bus glitch) changes no flag.
- R7: Only the address captured early in the phase counts. A change of address later in the same high phase has no effect.
- R8: With default parameters, a flag takes its new value at the fifth rising `clk` edge after `phi0` rises, and holds its old value through the fourth.
- R9: A `phi0` high pulse that lasts only one `clk` cycle throws no switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| phi0 | input | 1 | Asynchronous bus phase, high when the address is valid |
| addr | input | 16 | Asynchronous CPU address bus |
| page_sel | output | 1 | Display page-select flag |
| gfx_mode | output | 1 | Graphics-mode flag |

## Verification
Each input crosses two synchronizer stages, then spends one cycle in the settle state and one in apply. A flag therefore moves at the fifth `clk` edge after `phi0` rises. The latency check samples at the falling edge after the fourth edge, where the old value is expected, and again after the fifth, where the new value is expected. All other results are compared by the scoreboard monitor only after the driver has lowered the phase and waited eight more cycles, so every update and every rejected glitch has settled before the comparison.

// File: rtl/disp_switch_pkg.sv
package disp_switch_pkg;

    localparam int ADDR_W   = 16;
    localparam int NUM_SW   = 2;
    localparam int SW_PAGE  = 0;
    localparam int SW_GFX   = 1;
    localparam int BASE_ADR = 'hC054;

    typedef enum logic [1:0] {
        ST_LOW    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_APPLY  = 2'd2,
        ST_HOLD   = 2'd3
    } phase_state_e;

endpackage

// File: rtl/disp_bus_sync.sv
module disp_bus_sync #(
    parameter int WIDTH  = 17,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/disp_phase_fsm.sv
module disp_phase_fsm
    import disp_switch_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_s,
    output logic capture_en,
    output logic apply_en
);

    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    phase_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic settle_done;

    assign settle_done = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOW;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != ST_SETTLE) cnt_q <= '0;
        else if (!settle_done)           cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:    if (phase_s) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!phase_s)         state_d = ST_LOW;
                else if (settle_done) state_d = ST_APPLY;
            end
            ST_APPLY:  state_d = ST_HOLD;
            ST_HOLD:   if (!phase_s) state_d = ST_LOW;
            default:   state_d = ST_LOW;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        apply_en   = 1'b0;
        unique case (state_q)
            ST_SETTLE: capture_en = phase_s && settle_done;
            ST_APPLY:  apply_en   = phase_s;
            ST_LOW, ST_HOLD: ;
            default: ;
        endcase
    end

    // R7
    single_capture_chk: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> !capture_en);

    // R8
    apply_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        apply_en |-> $past(capture_en));

    // R9
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({capture_en, apply_en}));

endmodule

// File: rtl/disp_addr_decode.sv
module disp_addr_decode
    import disp_switch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic [ADDR_W-1:0] addr_s,
    output logic [NUM_SW-1:0] set_v,
    output logic [NUM_SW-1:0] clr_v
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)             addr_q <= '0;
        else if (capture_en) addr_q <= addr_s;
    end

    generate
        for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
            localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADR + 2 * i);
            localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADR + 2 * i + 1);
            assign clr_v[i] = (addr_q == CLR_A);
            assign set_v[i] = (addr_q == SET_A);
        end
    endgenerate

    // R7
    captured_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !capture_en |=> $stable(addr_q));

endmodule

// File: rtl/disp_switch_bank.sv
module disp_switch_bank
    import disp_switch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              apply_en,
    input  logic [NUM_SW-1:0] set_v,
    input  logic [NUM_SW-1:0] clr_v,
    output logic [NUM_SW-1:0] flags
);

    always_ff @(posedge clk) begin
        if (rst)           flags <= '0;
        else if (apply_en) flags <= (flags & ~clr_v) | set_v;
    end

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !apply_en |=> $stable(flags));

endmodule

// File: rtl/disp_switch_top.sv
module disp_switch_top
    import disp_switch_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi0,
    input  logic [ADDR_W-1:0] addr,
    output logic              page_sel,
    output logic              gfx_mode
);

    localparam int BUS_W = ADDR_W + 1;

    logic [BUS_W-1:0]  bus_s;
    logic              phase_s;
    logic [ADDR_W-1:0] addr_s;
    logic              capture_en, apply_en;
    logic [NUM_SW-1:0] set_v, clr_v, flags;

    disp_bus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d_async({phi0, addr}), .d_sync(bus_s)
    );

    assign phase_s = bus_s[BUS_W-1];
    assign addr_s  = bus_s[ADDR_W-1:0];

    disp_phase_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_fsm (
        .clk(clk), .rst(rst), .phase_s(phase_s),
        .capture_en(capture_en), .apply_en(apply_en)
    );

    disp_addr_decode i_dec (
        .clk(clk), .rst(rst), .capture_en(capture_en), .addr_s(addr_s),
        .set_v(set_v), .clr_v(clr_v)
    );

    disp_switch_bank i_bank (
        .clk(clk), .rst(rst), .apply_en(apply_en),
        .set_v(set_v), .clr_v(clr_v), .flags(flags)
    );

    assign page_sel = flags[SW_PAGE];
    assign gfx_mode = flags[SW_GFX];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (page_sel == 1'b0 && gfx_mode == 1'b0));

    // R6
    no_change_phase_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!phase_s && !$past(phase_s)) |=> $stable(flags));

endmodule

// File: tb/test_disp_switch_top.sv
module test_disp_switch_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi0 = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        page_sel, gfx_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  page;
        logic  gfx;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_switch_top i_disp_switch_top (
        .clk(clk), .rst(rst), .phi0(phi0), .addr(addr),
        .page_sel(page_sel), .gfx_mode(gfx_mode)
    );

    task automatic check(input string tag, input logic p_exp, input logic g_exp);
        checks++;
        if (page_sel !== p_exp || gfx_mode !== g_exp) begin
            errors++;
            $display("FAIL %s: page=%b gfx=%b expected page=%b gfx=%b",
                     tag, page_sel, gfx_mode, p_exp, g_exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus phase; optional glitch address driven right after the fall.
    task automatic bus_cycle(input logic [15:0] a, input int high_n,
                             input bit glitch, input logic [15:0] g_addr,
                             input logic p_exp, input logic g_exp, input string tag);
        @(negedge clk);
        addr = a;
        phi0 = 1'b1;
        wait_n(high_n);
        phi0 = 1'b0;
        if (glitch) addr = g_addr;
        wait_n(8);
        addr = 16'h0000;
        sb_q.push_back('{page: p_exp, gfx: g_exp, tag: tag});
        wait (sb_q.size() == 0);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, e.page, e.gfx);
            end
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        check("R1 reset state", 1'b0, 1'b0);

        bus_cycle(16'hC055, 10, 0, 16'h0, 1'b1, 1'b0, "R2 set page");
        bus_cycle(16'hC057, 10, 0, 16'h0, 1'b1, 1'b1, "R3 set gfx");
        bus_cycle(16'hC054, 10, 0, 16'h0, 1'b0, 1'b1, "R2 clear page");
        bus_cycle(16'hC058, 10, 0, 16'h0, 1'b0, 1'b1, "R4 other switch addr");
        bus_cycle(16'h0700, 10, 0, 16'h0, 1'b0, 1'b1, "R4 memory addr");

        // R5: switch address without any phase
        @(negedge clk);
        addr = 16'hC055;
        wait_n(12);
        addr = 16'h0000;
        wait_n(2);
        check("R5 phase low ignored", 1'b0, 1'b1);

        bus_cycle(16'hC054, 10, 1, 16'hC055, 1'b0, 1'b1, "R6 glitch after fall");
        bus_cycle(16'hC056, 10, 1, 16'hC057, 1'b0, 1'b0, "R6 gfx glitch / R3 clear gfx");
        bus_cycle(16'hC055, 1, 0, 16'h0, 1'b0, 1'b0, "R9 short phase");

        // R7: address switches to C054 late in a C055 phase
        @(negedge clk);
        addr = 16'hC055;
        phi0 = 1'b1;
        wait_n(3);
        addr = 16'hC054;
        wait_n(7);
        phi0 = 1'b0;
        wait_n(8);
        addr = 16'h0000;
        check("R7 late address ignored", 1'b1, 1'b0);

        // R8: latency, old value through edge 4, new at edge 5
        @(negedge clk);
        addr = 16'hC057;
        phi0 = 1'b1;
        wait_n(4);
        check("R8 before fifth edge", 1'b1, 1'b0);
        wait_n(1);
        check("R8 at fifth edge", 1'b1, 1'b1);
        wait_n(5);
        phi0 = 1'b0;
        wait_n(8);
        addr = 16'h0000;

        // R1: reset mid-operation
        rst = 1'b1;
        wait_n(1);
        rst = 1'b0;
        check("R1 reset clears flags", 1'b0, 1'b0);

        bus_cycle(16'hC055, 10, 0, 16'h0, 1'b1, 1'b0, "R2 set after reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule